// File: doc/BRIEF.md
# Streaming 2D Stencil Convolution Filter

This block filters an 8-bit grayscale frame that arrives as a raster-order pixel stream, one pixel per clock, and returns a frame of the same size made of signed weighted sums. Each result is centred on its own pixel and covers a KSIZE x KSIZE neighbourhood (3 x 3 by default). Neighbours that fall outside the frame add nothing. The frame is IMG_W x IMG_H (1000 x 30 by default). The block reads each input pixel once. It keeps the most recent rows in on-chip line memories and keeps the active neighbourhood in a shift-register window.

A start-of-frame flag on the first input pixel starts a frame. A centred result needs the pixel one row below and one column to the right, so output n is produced when input n+IMG_W+1 is taken. When the last input has arrived, the block inserts KSIZE/2*IMG_W+KSIZE/2 zero padding steps of its own so that the last row still comes out. The output stream marks the first result and the last result of each row. Coefficients are loaded through a write port as row index, column index and data, and they can change only between frames.

The control is a four-state machine:
- IDLE: waits for a pixel that has the start flag.
- FILL: takes pixels before any result is due.
- RUN: takes one pixel and gives one result per step.
- DRAIN: takes no input, inserts padding and gives the remaining results.

The transitions are:
- IDLE to FILL when the start pixel is accepted.
- FILL to RUN after input IMG_W.
- RUN to DRAIN after the last input pixel.
- DRAIN to IDLE after the last result.

One step is taken only when the output register is empty or is being read. This means output backpressure freezes the whole pipeline.

Top module: `stencil_filter2d`

## Requirements
- R1: After reset, out_valid is 0 and in_ready is 1, and no result appears until a frame is started.
- R2: The result for pixel (x,y) equals the sum over r,c in 0..KSIZE-1 of coef(r,c) * pixel(x+c-KSIZE/2, y+r-KSIZE/2). Row index r=0 is the row above (given on coef_row) and column index c=0 is the column to the left (given on coef_col). Pixels are unsigned and coefficients are signed two's complement.
- R3: A neighbour whose column lies outside 0..IMG_W-1 or whose row lies outside 0..IMG_H-1 contributes zero, on all four frame edges.
- R4: Each frame gives exactly IMG_W*IMG_H results in raster order, including the last row. in_ready is 0 while the padding steps run. After the last result the block is idle again, with out_valid 0 and in_ready 1.
- R5: out_sof is 1 on the first result of a frame and 0 on all others. out_eol is 1 exactly on results with x = IMG_W-1.
- R6: The result for raster position n is presented in the cycle after the clock edge that accepts input position n+IMG_W+1. The first result of a frame follows the acceptance of IMG_W+2 pixels. With continuous input and out_ready held at 1, results come on consecutive cycles.
- R7: While out_valid is 1 and out_ready is 0, the output holds its value and in_ready is 0. Results are never lost or repeated under any backpressure or input gap pattern.
- R8: In IDLE, a valid pixel without the start flag is consumed (in_ready 1) and discarded. It produces no result and has no effect on the next frame.
- R9: A coefficient write is applied only in IDLE. A write while a frame is in progress changes neither that frame nor later frames.
- R10: A coefficient write whose row or column index is KSIZE or more is ignored. It does not alias onto another coefficient.
- R11: Sums are exact in the ACC_W-bit (20-bit) signed result at both extremes: all pixels 255 with all coefficients +127, and with all coefficients -128.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Block accepts an input pixel |
| in_sof | input | 1 | Input pixel is the first of a frame |
| in_pixel | input | PIX_W | Unsigned pixel value |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer takes the result |
| out_sof | output | 1 | Result is the first of the frame |
| out_eol | output | 1 | Result is the last of its row |
| out_sum | output | ACC_W | Signed weighted sum |
| coef_we | input | 1 | Coefficient write strobe |
| coef_row | input | clog2(KSIZE) | Kernel row index of the write |
| coef_col | input | clog2(KSIZE) | Kernel column index of the write |
| coef_data | input | COEF_W | Signed coefficient value |

## Verification
Each result is registered at the same edge that accepts the input IMG_W+1 positions later in raster order, or at the matching padding step. It therefore appears one cycle after that acceptance and stays until the handshake completes. The bench drives inputs and samples outputs one time unit after the falling edge. At that point every register in the path has settled, so a result is compared only in a cycle where both out_valid and out_ready are high. For uninterrupted frames, a counter of accepted pixels is read when the first result appears, to check the IMG_W+2 pixel lead. The count of cycles between the first and the last result checks that results come out back-to-back.

// File: rtl/stencil_pkg.sv
package stencil_pkg;

    // Frame sequencing states of the stencil controller
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FILL  = 2'd1,
        ST_RUN   = 2'd2,
        ST_DRAIN = 2'd3
    } stencil_state_e;

endpackage

// File: rtl/stencil_ctrl.sv
module stencil_ctrl
    import stencil_pkg::*;
#(
    parameter  int IMG_W = 1000,
    parameter  int IMG_H = 30,
    parameter  int KSIZE = 3,
    localparam int X_W   = $clog2(IMG_W),
    localparam int Y_W   = $clog2(IMG_H)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           in_valid,
    input  logic           in_sof,
    input  logic           out_valid,
    input  logic           out_ready,
    output logic           in_ready,
    output logic           adv,
    output logic           emit,
    output logic           pad,
    output logic           idle,
    output logic [X_W-1:0] cx,
    output logic [Y_W-1:0] cy
);

    localparam int HALF   = KSIZE / 2;
    localparam int LAG    = HALF * IMG_W + HALF;
    localparam int NPIX   = IMG_W * IMG_H;
    localparam int LAST   = NPIX + LAG - 1;
    localparam int SLOT_W = $clog2(LAST + 1);

    stencil_state_e    state_q, state_d;
    logic [SLOT_W-1:0] slot_q;
    logic [X_W-1:0]    ox_q;
    logic [Y_W-1:0]    oy_q;
    logic              can_go;

    // A step may only be taken when the output register is free
    assign can_go = !out_valid || out_ready;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (adv) state_d = ST_FILL;
            end
            ST_FILL: begin
                if (adv && slot_q == SLOT_W'(LAG - 1)) state_d = ST_RUN;
            end
            ST_RUN: begin
                if (adv && slot_q == SLOT_W'(NPIX - 1)) state_d = ST_DRAIN;
            end
            ST_DRAIN: begin
                if (adv && slot_q == SLOT_W'(LAST)) state_d = ST_IDLE;
            end
        endcase
    end

    // Per-state outputs
    always_comb begin
        in_ready = 1'b0;
        adv      = 1'b0;
        emit     = 1'b0;
        pad      = 1'b0;
        idle     = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                idle     = 1'b1;
                in_ready = can_go;
                adv      = can_go && in_valid && in_sof;
            end
            ST_FILL: begin
                in_ready = can_go;
                adv      = can_go && in_valid;
            end
            ST_RUN: begin
                in_ready = can_go;
                adv      = can_go && in_valid;
                emit     = 1'b1;
            end
            ST_DRAIN: begin
                adv      = can_go;
                emit     = 1'b1;
                pad      = 1'b1;
            end
        endcase
    end

    // Step counter and output coordinates
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q <= '0;
            ox_q   <= '0;
            oy_q   <= '0;
        end else if (adv) begin
            if (state_d == ST_IDLE) begin
                slot_q <= '0;
            end else begin
                slot_q <= slot_q + 1'b1;
            end
            if (emit) begin
                if (ox_q == X_W'(IMG_W - 1)) begin
                    ox_q <= '0;
                    oy_q <= (oy_q == Y_W'(IMG_H - 1)) ? '0 : oy_q + 1'b1;
                end else begin
                    ox_q <= ox_q + 1'b1;
                end
            end
        end
    end

    assign cx = ox_q;
    assign cy = oy_q;

endmodule

// File: rtl/stencil_linebuf.sv
module stencil_linebuf #(
    parameter  int IMG_W = 1000,
    parameter  int KSIZE = 3,
    parameter  int PIX_W = 8,
    localparam int X_W   = $clog2(IMG_W),
    localparam int NBUF  = KSIZE - 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        adv,
    input  logic [PIX_W-1:0]            pix_in,
    output logic [KSIZE-1:0][PIX_W-1:0] col_o
);

    logic [X_W-1:0]              ptr_q;
    logic [NBUF:0][PIX_W-1:0]    chain;

    assign chain[0] = pix_in;

    // Each stage delays the stream by exactly one row
    for (genvar j = 0; j < NBUF; j++) begin : g_row
        logic [PIX_W-1:0] mem [IMG_W];
        assign chain[j+1] = mem[ptr_q];
        always_ff @(posedge clk) begin
            if (adv) mem[ptr_q] <= chain[j];
        end
    end

    // Window row r = 0 is the oldest row, r = KSIZE-1 the incoming one
    for (genvar r = 0; r < KSIZE; r++) begin : g_col
        assign col_o[r] = chain[KSIZE-1-r];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (adv) begin
            ptr_q <= (ptr_q == X_W'(IMG_W - 1)) ? '0 : ptr_q + 1'b1;
        end
    end

endmodule

// File: rtl/stencil_coef.sv
module stencil_coef #(
    parameter  int KSIZE  = 3,
    parameter  int COEF_W = 8,
    localparam int IDX_W  = $clog2(KSIZE),
    localparam int NTAP   = KSIZE * KSIZE
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        we,
    input  logic                        allow,
    input  logic [IDX_W-1:0]            row,
    input  logic [IDX_W-1:0]            col,
    input  logic [COEF_W-1:0]           data,
    output logic [NTAP-1:0][COEF_W-1:0] coef_o
);

    logic in_range;
    int   widx;

    assign in_range = (int'(row) < KSIZE) && (int'(col) < KSIZE);
    assign widx     = int'(row) * KSIZE + int'(col);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            coef_o <= '0;
        end else if (we && allow && in_range) begin
            for (int i = 0; i < NTAP; i++) begin
                if (widx == i) coef_o[i] <= data;
            end
        end
    end

endmodule

// File: rtl/stencil_window_mac.sv
module stencil_window_mac #(
    parameter  int IMG_W  = 1000,
    parameter  int IMG_H  = 30,
    parameter  int KSIZE  = 3,
    parameter  int PIX_W  = 8,
    parameter  int COEF_W = 8,
    parameter  int ACC_W  = 20,
    localparam int X_W    = $clog2(IMG_W),
    localparam int Y_W    = $clog2(IMG_H),
    localparam int NTAP   = KSIZE * KSIZE
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        adv,
    input  logic                        emit,
    input  logic                        out_ready,
    input  logic [X_W-1:0]              cx,
    input  logic [Y_W-1:0]              cy,
    input  logic [KSIZE-1:0][PIX_W-1:0] new_col,
    input  logic [NTAP-1:0][COEF_W-1:0] coef,
    output logic                        out_valid,
    output logic                        out_sof,
    output logic                        out_eol,
    output logic signed [ACC_W-1:0]     out_sum
);

    localparam int HALF = KSIZE / 2;

    // Indexed [column][row]; the newest column comes straight from the line buffers
    logic [KSIZE-2:0][KSIZE-1:0][PIX_W-1:0] win_q;
    logic [KSIZE-1:0][KSIZE-1:0][PIX_W-1:0] full;
    logic [KSIZE-1:0]                       row_ok;
    logic [KSIZE-1:0]                       col_ok;
    logic signed [ACC_W-1:0]                prod [NTAP];
    logic signed [ACC_W-1:0]                acc;

    for (genvar c = 0; c < KSIZE - 1; c++) begin : g_old
        assign full[c] = win_q[c];
    end
    assign full[KSIZE-1] = new_col;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_q <= '0;
        end else if (adv) begin
            for (int c = 0; c < KSIZE - 2; c++) begin
                win_q[c] <= win_q[c+1];
            end
            win_q[KSIZE-2] <= new_col;
        end
    end

    // Frame-edge masks for the centre (cx, cy)
    always_comb begin
        for (int r = 0; r < KSIZE; r++) begin
            row_ok[r] = (int'(cy) + r >= HALF) && (int'(cy) + r < IMG_H + HALF);
        end
        for (int c = 0; c < KSIZE; c++) begin
            col_ok[c] = (int'(cx) + c >= HALF) && (int'(cx) + c < IMG_W + HALF);
        end
    end

    for (genvar r = 0; r < KSIZE; r++) begin : g_r
        for (genvar c = 0; c < KSIZE; c++) begin : g_c
            logic signed [ACC_W-1:0] px_e;
            logic signed [ACC_W-1:0] cf_e;
            assign px_e = {{(ACC_W-PIX_W){1'b0}}, full[c][r]};
            assign cf_e = {{(ACC_W-COEF_W){coef[r*KSIZE+c][COEF_W-1]}}, coef[r*KSIZE+c]};
            assign prod[r*KSIZE+c] = (row_ok[r] && col_ok[c]) ? px_e * cf_e : '0;
        end
    end

    always_comb begin
        acc = '0;
        for (int i = 0; i < NTAP; i++) begin
            acc = acc + prod[i];
        end
    end

    // Output register: loaded on every step, cleared once consumed
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_sof   <= 1'b0;
            out_eol   <= 1'b0;
            out_sum   <= '0;
        end else if (adv) begin
            out_valid <= emit;
            out_sof   <= emit && (cx == '0) && (cy == '0);
            out_eol   <= emit && (cx == X_W'(IMG_W - 1));
            out_sum   <= acc;
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end

endmodule

// File: rtl/stencil_filter2d.sv
module stencil_filter2d #(
    parameter  int IMG_W  = 1000,
    parameter  int IMG_H  = 30,
    parameter  int KSIZE  = 3,
    parameter  int PIX_W  = 8,
    parameter  int COEF_W = 8,
    parameter  int ACC_W  = 20,
    localparam int IDX_W  = $clog2(KSIZE)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    output logic                    in_ready,
    input  logic                    in_sof,
    input  logic [PIX_W-1:0]        in_pixel,
    output logic                    out_valid,
    input  logic                    out_ready,
    output logic                    out_sof,
    output logic                    out_eol,
    output logic signed [ACC_W-1:0] out_sum,
    input  logic                    coef_we,
    input  logic [IDX_W-1:0]        coef_row,
    input  logic [IDX_W-1:0]        coef_col,
    input  logic [COEF_W-1:0]       coef_data
);

    localparam int X_W  = $clog2(IMG_W);
    localparam int Y_W  = $clog2(IMG_H);
    localparam int NTAP = KSIZE * KSIZE;

    logic                        adv, emit, pad, idle;
    logic [X_W-1:0]              cx;
    logic [Y_W-1:0]              cy;
    logic [PIX_W-1:0]            pix_step;
    logic [KSIZE-1:0][PIX_W-1:0] new_col;
    logic [NTAP-1:0][COEF_W-1:0] coef;

    assign pix_step = pad ? '0 : in_pixel;

    stencil_ctrl #(
        .IMG_W(IMG_W), .IMG_H(IMG_H), .KSIZE(KSIZE)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
        .out_valid(out_valid), .out_ready(out_ready), .in_ready(in_ready),
        .adv(adv), .emit(emit), .pad(pad), .idle(idle), .cx(cx), .cy(cy)
    );

    stencil_linebuf #(
        .IMG_W(IMG_W), .KSIZE(KSIZE), .PIX_W(PIX_W)
    ) u_lbuf (
        .clk(clk), .rst_n(rst_n), .adv(adv), .pix_in(pix_step), .col_o(new_col)
    );

    stencil_coef #(
        .KSIZE(KSIZE), .COEF_W(COEF_W)
    ) u_coef (
        .clk(clk), .rst_n(rst_n), .we(coef_we), .allow(idle),
        .row(coef_row), .col(coef_col), .data(coef_data), .coef_o(coef)
    );

    stencil_window_mac #(
        .IMG_W(IMG_W), .IMG_H(IMG_H), .KSIZE(KSIZE),
        .PIX_W(PIX_W), .COEF_W(COEF_W), .ACC_W(ACC_W)
    ) u_mac (
        .clk(clk), .rst_n(rst_n), .adv(adv), .emit(emit), .out_ready(out_ready),
        .cx(cx), .cy(cy), .new_col(new_col), .coef(coef),
        .out_valid(out_valid), .out_sof(out_sof), .out_eol(out_eol), .out_sum(out_sum)
    );

endmodule

// File: rtl/stencil_filter2d_chk.sv
module stencil_filter2d_chk #(
    parameter int IMG_W = 1000,
    parameter int IMG_H = 30,
    parameter int ACC_W = 20
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    in_ready,
    input logic                    out_valid,
    input logic                    out_ready,
    input logic                    out_sof,
    input logic                    out_eol,
    input logic signed [ACC_W-1:0] out_sum
);

    localparam int NPIX  = IMG_W * IMG_H;
    localparam int CNT_W = $clog2(NPIX + 1);
    localparam int COL_W = $clog2(IMG_W + 1);

    logic [CNT_W-1:0] res_cnt;
    logic [COL_W-1:0] res_col;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_cnt <= '0;
            res_col <= '0;
        end else if (out_valid && out_ready) begin
            res_cnt <= (res_cnt == CNT_W'(NPIX - 1)) ? '0 : res_cnt + 1'b1;
            res_col <= (res_col == COL_W'(IMG_W - 1)) ? '0 : res_col + 1'b1;
        end
    end

    // R1
    quiet_after_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> !out_valid);

    // R7
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_sum) && $stable(out_sof) && $stable(out_eol));

    // R7
    stall_blocks_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |-> !in_ready);

    // R5
    sof_position_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_sof == (res_cnt == '0)));

    // R5
    eol_position_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_eol == (res_col == COL_W'(IMG_W - 1))));

endmodule

bind stencil_filter2d stencil_filter2d_chk #(
    .IMG_W(IMG_W), .IMG_H(IMG_H), .ACC_W(ACC_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .out_valid(out_valid),
    .out_ready(out_ready), .out_sof(out_sof), .out_eol(out_eol), .out_sum(out_sum)
);

// File: tb/tb_stencil_filter2d.sv
`timescale 1ns/1ps
module tb_stencil_filter2d;

    localparam int TW   = 6;
    localparam int TH   = 4;
    localparam int KS   = 3;
    localparam int NPIX = TW * TH;
    localparam int LAG  = TW + 1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic              in_sof = 1'b0;
    logic [7:0]        in_pixel = '0;
    logic              out_ready = 1'b0;
    logic              coef_we = 1'b0;
    logic [1:0]        coef_row = '0;
    logic [1:0]        coef_col = '0;
    logic [7:0]        coef_data = '0;
    logic              in_ready, out_valid, out_sof, out_eol;
    logic signed [19:0] out_sum;

    int nvec = 0;
    int nfail = 0;
    int cyc = 0;
    int acc_cnt = 0;
    int img [TH][TW];
    int cm [KS][KS];

    // {pattern[7:5], coefficient set[4:2], input gaps[0], output stalls[1]}
    localparam logic [7:0] VEC [6] = '{
        {3'd0, 3'd0, 2'd0},   // R2 R3 R6: ramp, mixed signs, continuous
        {3'd3, 3'd3, 2'd3},   // R7: scrambled, identity, gaps and stalls
        {3'd1, 3'd1, 2'd0},   // R11: all 255, all +127
        {3'd1, 3'd2, 2'd2},   // R11: all 255, all -128, stalls
        {3'd0, 3'd4, 2'd1},   // R3: corner tap only, input gaps
        {3'd3, 3'd0, 2'd3}    // R2 R7: scrambled, mixed signs, gaps and stalls
    };

    stencil_filter2d #(.IMG_W(TW), .IMG_H(TH)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_sof(in_sof), .in_pixel(in_pixel), .out_valid(out_valid),
        .out_ready(out_ready), .out_sof(out_sof), .out_eol(out_eol),
        .out_sum(out_sum), .coef_we(coef_we), .coef_row(coef_row),
        .coef_col(coef_col), .coef_data(coef_data)
    );

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;
    always @(posedge clk) if (rst_n && in_valid && in_ready) acc_cnt <= acc_cnt + 1;

    task automatic check(bit ok, string req, int got, int exp);
        nvec++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    endtask

    function automatic int ref_at(int x, int y);
        int s = 0;
        for (int r = 0; r < KS; r++) begin
            for (int c = 0; c < KS; c++) begin
                int xx = x + c - 1;
                int yy = y + r - 1;
                if (xx >= 0 && xx < TW && yy >= 0 && yy < TH) s += cm[r][c] * img[yy][xx];
            end
        end
        return s;
    endfunction

    task automatic gen_img(int pat);
        for (int y = 0; y < TH; y++) begin
            for (int x = 0; x < TW; x++) begin
                case (pat)
                    0:       img[y][x] = (x * 37 + y * 11) % 256;
                    1:       img[y][x] = 255;
                    default: img[y][x] = (x * x * 7 + y * 53 + x * y * 5 + 13) % 256;
                endcase
            end
        end
    endtask

    task automatic write_coef(int r, int c, int v);
        @(negedge clk);
        coef_we = 1'b1; coef_row = 2'(r); coef_col = 2'(c); coef_data = 8'(v);
        @(negedge clk);
        coef_we = 1'b0;
    endtask

    task automatic load_cset(int id);
        for (int r = 0; r < KS; r++) begin
            for (int c = 0; c < KS; c++) begin
                int v;
                case (id)
                    0:       v = (r * 3 + c) * 9 - 37;
                    1:       v = 127;
                    2:       v = -128;
                    3:       v = (r == 1 && c == 1) ? 1 : 0;
                    default: v = (r == 0 && c == 0) ? 1 : 0;
                endcase
                cm[r][c] = v;
                write_coef(r, c, v);
            end
        end
    endtask

    task automatic produce(bit gap, bit inject);
        int i = 0;
        bit injected = 1'b0;
        bit tick = 1'b0;
        while (i < NPIX) begin
            @(negedge clk);
            coef_we = 1'b0;
            if (inject && !injected && i == 10) begin
                coef_we = 1'b1; coef_row = 2'd1; coef_col = 2'd1; coef_data = 8'd100;
                injected = 1'b1;
            end
            tick = ~tick;
            if (gap && tick) begin
                in_valid = 1'b0;
            end else begin
                in_valid = 1'b1;
                in_pixel = 8'(img[i / TW][i % TW]);
                in_sof   = (i == 0);
            end
            #1;
            if (in_valid && in_ready) i++;
        end
        @(negedge clk);
        in_valid = 1'b0; in_sof = 1'b0; coef_we = 1'b0;
        #1;
        check(in_ready == 1'b0, "R4 drain in_ready", int'(in_ready), 0);
    endtask

    task automatic consume(bit bp, bit timing);
        int k = 0;
        int base = acc_cnt;
        int first_acc = 0;
        int first_cyc = 0;
        int last_cyc = 0;
        while (k < NPIX) begin
            @(negedge clk);
            out_ready = bp ? (cyc % 3 != 0) : 1'b1;
            #1;
            if (out_valid && out_ready) begin
                int x = k % TW;
                int y = k / TW;
                int exp = ref_at(x, y);
                check(int'(out_sum) == exp, "R2 R3 R7 R11 sum", int'(out_sum), exp);
                check(out_sof == (k == 0) && out_eol == (x == TW - 1), "R5 flags",
                      int'({out_sof, out_eol}), int'({k == 0, x == TW - 1}));
                if (k == 0) begin
                    first_acc = acc_cnt;
                    first_cyc = cyc;
                end
                if (k == NPIX - 1) last_cyc = cyc;
                k++;
            end
        end
        @(negedge clk);
        out_ready = 1'b1;
        if (timing) begin
            check(first_acc - base == LAG + 1, "R6 first-result lead", first_acc - base, LAG + 1);
            check(last_cyc - first_cyc == NPIX - 1, "R6 back-to-back", last_cyc - first_cyc, NPIX - 1);
        end
    endtask

    task automatic post_idle();
        for (int n = 0; n < 4; n++) begin
            @(negedge clk);
            #1;
            check(!out_valid && in_ready, "R4 idle after frame", int'({out_valid, in_ready}), 1);
        end
    endtask

    task automatic run_frame(bit gap, bit bp, bit inject, bit timing);
        fork
            produce(gap, inject);
            consume(bp, timing);
        join
        post_idle();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nfail++;
        $display("FAIL R4: watchdog expired, got hang expected completion");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        // R1
        check(out_valid == 1'b0, "R1 out_valid", int'(out_valid), 0);
        check(in_ready == 1'b1, "R1 in_ready", int'(in_ready), 1);

        for (int t = 0; t < 6; t++) begin
            gen_img(int'(VEC[t][7:5]));
            load_cset(int'(VEC[t][4:2]));
            run_frame(VEC[t][0], VEC[t][1], 1'b0, VEC[t][1:0] == 2'd0);
        end

        // R8: stray pixels without start flag while idle
        load_cset(3);
        gen_img(3);
        for (int s = 0; s < 4; s++) begin
            @(negedge clk);
            in_valid = 1'b1; in_sof = 1'b0; in_pixel = 8'hC3;
            #1;
            check(in_ready == 1'b1, "R8 stray consumed", int'(in_ready), 1);
        end
        @(negedge clk);
        in_valid = 1'b0;
        #1;
        check(out_valid == 1'b0, "R8 no result from stray", int'(out_valid), 0);
        run_frame(1'b0, 1'b0, 1'b0, 1'b1);

        // R9: write during a frame is ignored now and later
        gen_img(0);
        run_frame(1'b0, 1'b0, 1'b1, 1'b0);
        run_frame(1'b1, 1'b0, 1'b0, 1'b0);

        // R10: out-of-range indices must not alias
        write_coef(0, 3, 77);
        write_coef(3, 0, 55);
        gen_img(3);
        run_frame(1'b0, 1'b1, 1'b0, 1'b0);

        summary();
        $finish;
    end

endmodule